// File: doc/BRIEF.md
# Sequence-Locked Protected Control Register

This block keeps a single mode-control bit safe from stray or runaway software writes. The bit sits behind a small register window on a simple synchronous write bus with a separate combinational read port. To change it, software first writes a fixed key byte to a write-only command register. It then writes the protected register three times: the intended byte, the bitwise complement of that byte, and the intended byte again. Only the last of these writes takes effect, and only bit 0 of the byte is stored.

Any deviation leaves the bit as it was and raises a sticky protection-error flag in a status register. Examples are a protected write with no key, a wrong complement, a final byte that does not match, or a write to another address in the middle of the sequence. Two more sticky flags in the same status register capture one-cycle error pulses from an external programming engine. Software clears each flag by writing 0 to its bit. A completed sequence re-locks the register, so every change needs a fresh key.

Register addresses: command at 0xFFA0, protected control at 0xFFA1, status at 0xFFA2. The asynchronous active-low reset is released synchronously inside the block.

Top module: `seq_lock_ctrl`

## Requirements
- R1: After reset the protected bit reads 0, the status register reads 0x00 and the sequencer is locked.
- R2: A write of 0xA5 to 0xFFA0, followed by writes of V, ~V and V to 0xFFA1, sets the protected bit to V[0] one clock after the third write, and leaves status bit 0 at 0.
- R3: The first two protected-register writes of a sequence leave the protected bit unchanged.
- R4: A write to 0xFFA1 while locked leaves the protected bit unchanged and sets status bit 0 (protection error).
- R5: All 8 bits are compared. A second write other than ~V, or a third write other than V, leaves the protected bit unchanged, sets status bit 0 and returns the sequencer to locked.
- R6: A completed sequence re-locks the register. A further V, ~V, V sequence without a new key write does not change the bit and sets status bit 0.
- R7: After the key write and before the third protected write, a write to any address other than 0xFFA1 aborts the sequence and sets status bit 0. This setting takes priority over a clear written to the status register in the same cycle.
- R8: A write to 0xFFA2 clears each status flag whose bit in the written byte is 0 and leaves the flags whose bit is 1 unchanged.
- R9: A one-cycle pulse on eng_err_i[0] sets status bit 1, and one on eng_err_i[1] sets status bit 2. Both flags stay set until cleared, and a pulse wins over a clear in the same cycle.
- R10: rd_data returns {7'b0, protected bit} at 0xFFA1 and {5'b0, flags[2:0]} at 0xFFA2. It returns 0x00 at 0xFFA0, which is write-only, and at any other address.
- R11: A non-key byte written to 0xFFA0 while locked raises no error and does not unlock the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| eng_err_i | input | 2 | Error pulses from the programming engine |
| mode_o | output | 1 | Protected mode bit |

## Verification
A sequencer stuck in the wrong state shows up at the very next protected write. It either changes mode_o when it should not, or sets status bit 0 when it should not, and both are visible through rd_data one clock after the write. Faulty flag logic shows up on the first status read after a pulse or a clear write. Faulty byte comparisons are exposed by sequences whose wrong bit is not bit 0, such as a complement that is wrong only in bit 7.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
  typedef enum logic [1:0] {
    SQ_LOCKED  = 2'd0,
    SQ_KEYED   = 2'd1,
    SQ_VALUE   = 2'd2,
    SQ_INVERSE = 2'd3
  } sq_state_t;
endpackage

// File: rtl/seqlock_rst_sync.sv
module seqlock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/seqlock_fsm.sv
module seqlock_fsm
  import seqlock_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,    // write to command register
  input  logic              ctrl_wr,   // write to protected register
  input  logic              other_wr,  // any write not to protected register
  input  logic [DATA_W-1:0] wdata,
  output logic              commit,
  output logic [DATA_W-1:0] commit_val,
  output logic              viol,
  output sq_state_t         state
);
  sq_state_t         st_q, st_d;
  logic [DATA_W-1:0] first_q;
  logic              cap_en;

  // next-state process
  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    commit = 1'b0;
    viol   = 1'b0;
    unique case (st_q)
      SQ_LOCKED: begin
        if (cmd_wr && (wdata == KEY)) st_d = SQ_KEYED;
        else if (ctrl_wr)             viol = 1'b1;
      end
      SQ_KEYED: begin
        if (ctrl_wr) begin
          cap_en = 1'b1;
          st_d   = SQ_VALUE;
        end else if (other_wr) begin
          viol = 1'b1;
          st_d = SQ_LOCKED;
        end
      end
      SQ_VALUE: begin
        if (ctrl_wr) begin
          if (wdata == ~first_q) st_d = SQ_INVERSE;
          else begin
            viol = 1'b1;
            st_d = SQ_LOCKED;
          end
        end else if (other_wr) begin
          viol = 1'b1;
          st_d = SQ_LOCKED;
        end
      end
      SQ_INVERSE: begin
        if (ctrl_wr) begin
          st_d = SQ_LOCKED;
          if (wdata == first_q) commit = 1'b1;
          else                  viol   = 1'b1;
        end else if (other_wr) begin
          viol = 1'b1;
          st_d = SQ_LOCKED;
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_LOCKED;
      first_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) first_q <= wdata;
    end
  end

  assign commit_val = first_q;
  assign state      = st_q;
endmodule

// File: rtl/seqlock_flags.sv
module seqlock_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] wmask,
  output logic [NFLAG-1:0] flags
);
  for (genvar b = 0; b < NFLAG; b++) begin : g_flag
    logic en, q;
    // a set pulse wins over a clear in the same cycle
    assign en = set[b] | (clr_wr & ~wmask[b]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= set[b];
    end
    assign flags[b] = q;
  end
endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seqlock_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                NENG        = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] KEY         = 8'hA5,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'hFFA0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hFFA1,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hFFA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NENG-1:0]   eng_err_i,
  output logic              mode_o
);
  localparam int NFLAG = NENG + 1;

  logic              srst_n;
  logic              cmd_wr, ctrl_wr, stat_wr, other_wr;
  logic              commit, viol;
  logic [DATA_W-1:0] commit_val;
  sq_state_t         sq_state;
  logic [NFLAG-1:0]  flags;
  logic              mode_q;

  seqlock_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  // write decode
  assign cmd_wr   = bus_wr && (bus_addr == CMD_ADDR);
  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_wr  = bus_wr && (bus_addr == STAT_ADDR);
  assign other_wr = bus_wr && (bus_addr != CTRL_ADDR);

  seqlock_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
    .clk(clk), .rst_n(srst_n),
    .cmd_wr(cmd_wr), .ctrl_wr(ctrl_wr), .other_wr(other_wr),
    .wdata(bus_wdata),
    .commit(commit), .commit_val(commit_val), .viol(viol),
    .state(sq_state)
  );

  seqlock_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(srst_n),
    .set({eng_err_i, viol}),
    .clr_wr(stat_wr),
    .wmask(bus_wdata[NFLAG-1:0]),
    .flags(flags)
  );

  // protected bit, enabled only by a completed sequence
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     mode_q <= 1'b0;
    else if (commit) mode_q <= commit_val[0];
  end

  assign mode_o = mode_q;

  // read port
  always_comb begin
    if (rd_addr == CTRL_ADDR)      rd_data = {{(DATA_W-1){1'b0}}, mode_q};
    else if (rd_addr == STAT_ADDR) rd_data = {{(DATA_W-NFLAG){1'b0}}, flags};
    else                           rd_data = '0;
  end
endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk
  import seqlock_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                NENG      = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFA1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFA2
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NENG-1:0]   eng_err_i,
  input logic              mode_o,
  input logic [NENG:0]     flags,
  input sq_state_t         sq_state
);
  logic past_ok;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R3: the protected bit only moves after a protected-register write
  a_r3_mode_only_on_ctrl_write: assert property (@(posedge clk) disable iff (!srst_n)
    (past_ok && !($past(bus_wr) && ($past(bus_addr) == CTRL_ADDR))) |-> $stable(mode_o));

  // R4: protected write while locked raises protection error
  a_r4_nokey_sets_err: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && (bus_addr == CTRL_ADDR) && (sq_state == SQ_LOCKED)) |=> flags[0]);

  // R7: foreign write mid-sequence aborts and flags
  a_r7_abort_sets_err: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && (bus_addr != CTRL_ADDR) && (sq_state != SQ_LOCKED))
      |=> (flags[0] && (sq_state == SQ_LOCKED)));

  // R9: engine pulses set their flags
  for (genvar e = 0; e < NENG; e++) begin : g_eng
    a_r9_engine_sets_flag: assert property (@(posedge clk) disable iff (!srst_n)
      eng_err_i[e] |=> flags[e+1]);
  end

  // R8: flags stay set unless a zero is written to their bit
  for (genvar b = 0; b <= NENG; b++) begin : g_stick
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!srst_n)
      (flags[b] && !(bus_wr && (bus_addr == STAT_ADDR) && !bus_wdata[b])) |=> flags[b]);
  end
endmodule

bind seq_lock_ctrl seqlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NENG(NENG),
  .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .eng_err_i(eng_err_i), .mode_o(mode_o),
  .flags(flags), .sq_state(sq_state)
);

// File: tb/sim_seq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_seq_lock_ctrl;
  localparam logic [15:0] A_CMD  = 16'hFFA0;
  localparam logic [15:0] A_CTRL = 16'hFFA1;
  localparam logic [15:0] A_STAT = 16'hFFA2;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [1:0]  eng_err_i;
  logic        mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  seq_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_err_i(eng_err_i), .mode_o(mode_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 16'h0000; bus_wdata = 8'h00;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse(input logic [1:0] p);
    @(negedge clk);
    eng_err_i = p;
    @(negedge clk);
    eng_err_i = 2'b00;
  endtask

  task automatic seq(input logic [7:0] v, input logic [7:0] inv, input logic [7:0] fin);
    wr(A_CMD, 8'hA5);
    wr(A_CTRL, v);
    wr(A_CTRL, inv);
    wr(A_CTRL, fin);
  endtask

  task automatic t_reset;
    rd_chk("R1 mode after reset", A_CTRL, 8'h00);
    rd_chk("R1 status after reset", A_STAT, 8'h00);
    chk("R1 mode_o after reset", {7'b0, mode_o}, 8'h00);
  endtask

  task automatic t_good;
    wr(A_CMD, 8'hA5);
    wr(A_CTRL, 8'h01);
    rd_chk("R3 after value write", A_CTRL, 8'h00);
    wr(A_CTRL, 8'hFE);
    rd_chk("R3 after inverse write", A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    rd_chk("R2 mode set to 1", A_CTRL, 8'h01);
    rd_chk("R2 no error", A_STAT, 8'h00);
    seq(8'h00, 8'hFF, 8'h00);
    rd_chk("R2 mode back to 0", A_CTRL, 8'h00);
    seq(8'h83, 8'h7C, 8'h83);
    rd_chk("R2 mode set by 0x83", A_CTRL, 8'h01);
    rd_chk("R2 still no error", A_STAT, 8'h00);
  endtask

  task automatic t_nokey;
    wr(A_CTRL, 8'h00);
    rd_chk("R4 mode unchanged", A_CTRL, 8'h01);
    rd_chk("R4 error flag", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_bad;
    seq(8'h00, 8'h7F, 8'h00);          // complement wrong in bit 7
    rd_chk("R5 bad inverse mode", A_CTRL, 8'h01);
    rd_chk("R5 bad inverse error", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
    seq(8'h00, 8'hFF, 8'h02);          // final byte mismatched
    rd_chk("R5 bad final mode", A_CTRL, 8'h01);
    rd_chk("R5 bad final error", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
    wr(A_CTRL, 8'h00);                 // back to locked
    rd_chk("R5 relocked error", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_fresh;
    seq(8'h00, 8'hFF, 8'h00);
    rd_chk("R6 first change", A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01); wr(A_CTRL, 8'hFE); wr(A_CTRL, 8'h01);
    rd_chk("R6 no change without key", A_CTRL, 8'h00);
    rd_chk("R6 error without key", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_abort;
    wr(A_CMD, 8'hA5);
    wr(A_CTRL, 8'h01);
    wr(A_STAT, 8'h00);                 // abort and clear at once
    rd_chk("R7 set beats clear", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
    wr(A_CTRL, 8'hFE); wr(A_CTRL, 8'h01);
    rd_chk("R7 aborted mode", A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_CMD, 8'hA5);
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'hFE);
    wr(A_CMD, 8'hA5);                  // command write mid-sequence
    rd_chk("R7 cmd abort error", A_STAT, 8'h01);
    wr(A_CTRL, 8'h01);
    rd_chk("R7 cmd abort mode", A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_nonkey;
    wr(A_CMD, 8'h3C);
    rd_chk("R11 no error on non-key", A_STAT, 8'h00);
    wr(A_CTRL, 8'h01);
    rd_chk("R11 still locked mode", A_CTRL, 8'h00);
    rd_chk("R11 still locked error", A_STAT, 8'h01);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_engine;
    pulse(2'b01);
    rd_chk("R9 engine bit1", A_STAT, 8'h02);
    repeat (3) @(negedge clk);
    rd_chk("R9 bit1 sticky", A_STAT, 8'h02);
    pulse(2'b10);
    rd_chk("R9 engine bit2", A_STAT, 8'h06);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h00; eng_err_i = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 16'h0000; eng_err_i = 2'b00;
    rd_chk("R9 pulse beats clear", A_STAT, 8'h02);
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_clear;
    pulse(2'b11);
    wr(A_CTRL, 8'h00);
    rd_chk("R8 all flags set", A_STAT, 8'h07);
    wr(A_STAT, 8'h05);
    rd_chk("R8 clear bit1 only", A_STAT, 8'h05);
    wr(A_STAT, 8'h06);
    rd_chk("R8 clear bit0 only", A_STAT, 8'h04);
    wr(A_STAT, 8'hFB);
    rd_chk("R8 clear bit2", A_STAT, 8'h00);
  endtask

  task automatic t_reads;
    seq(8'hFF, 8'h00, 8'hFF);
    rd_chk("R10 ctrl read", A_CTRL, 8'h01);
    chk("R10 mode_o", {7'b0, mode_o}, 8'h01);
    rd_chk("R10 cmd read zero", A_CMD, 8'h00);
    rd_chk("R10 unmapped read zero", 16'h1234, 8'h00);
    rd_chk("R10 status read", A_STAT, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rd_addr = '0; eng_err_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_good;
    t_nokey;
    t_bad;
    t_fresh;
    t_abort;
    t_nonkey;
    t_engine;
    t_clear;
    t_reads;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule